// File: doc/BRIEF.md
# Hashed Inverted Page Table Walker

This block turns a virtual page number, qualified by a process identifier, into a physical frame number. It does this by searching an inverted translation table held in an external synchronous memory. The table has exactly one entry per physical frame. Its size therefore follows the amount of physical memory and not the size of the virtual space. Each entry records which page of which process currently occupies that frame, together with a few attribute bits.

A request is hashed to a home slot. The block then reads a short run of consecutive slots, one per cycle, starting at that home slot and wrapping at the end of the table. It stops at the first entry whose page number and process identifier both equal the request. On a match it returns the slot index as the frame number. The search also ends when it reaches an empty slot or when the run is used up; either way it reports a fault. Each response carries the number of table reads that the lookup used.

The table base is an input. It is added to every slot index to form the memory address, so the table can sit anywhere in the memory's address space. Filling, replacing and evicting entries is left to other logic, as is servicing faults.

Top module: `ipt_walker`

## Requirements
- R1: After reset `req_ready` is 1, while `rsp_valid` and `mem_rd_en` are 0.
- R2: The home slot is an XOR fold. Take x = `req_vpn` XOR `req_pid`, with the identifier zero-extended into the low bits. Split x into IDX_W-bit slices starting at bit 0, zero-padding the top slice, and XOR the slices together. The first read is issued in the accepting cycle, at address `tbl_base` + home slot, modulo 2^ADDR_W.
- R3: The read for probe k (k = 0..PROBES-1) targets slot (home + k) mod 2^IDX_W, plus `tbl_base`. Reads are issued on consecutive cycles, and the slot index wraps from the last slot of the table to slot 0.
- R4: An entry word is laid out as vpn in bits [VPN_W-1:0], then pid, then flags [FLAG_W bits], with the valid bit at the top. An entry matches only when it is valid and both its vpn and its pid equal the request. On a match the response gives `rsp_hit`=1, `rsp_fault`=0, `rsp_pfn` = the matching slot index and `rsp_flags` = the entry's flags. Otherwise it gives `rsp_hit`=0, `rsp_fault`=1 and `rsp_flags`=0.
- R5: The search stops at the first matching slot; later slots are not read, even if they would also match. `rsp_probes` equals the position of the matching slot plus one.
- R6: Reading an entry whose valid bit is 0 ends the search with a fault. `rsp_probes` counts that read.
- R7: When all PROBES slots are valid but none matches, the response is a fault with `rsp_probes` = PROBES. A match beyond the run is never found.
- R8: `rsp_valid` is high for exactly one cycle per accepted request. It rises on the n-th rising edge after the accepting edge, where n is the reported `rsp_probes`.
- R9: `req_ready` is 0 from the edge after acceptance until the response cycle. Requests presented in that window are ignored. In the response cycle `req_ready` is 1, so a new request can be accepted in the same cycle that the previous response is delivered.
- R10: `mem_rd_en` is asserted exactly once per probe and never when no lookup is being started or searched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tbl_base | input | ADDR_W | Memory address of slot 0 of the table |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_pid | input | PID_W | Process identifier of the request |
| rsp_valid | output | 1 | Response fields are valid this cycle |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | No translation found |
| rsp_pfn | output | IDX_W | Physical frame number (slot index) on a hit |
| rsp_flags | output | FLAG_W | Attribute bits of the matching entry, 0 on a fault |
| rsp_probes | output | CNT_W | Number of table reads used by the lookup |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | ADDR_W | Table read address |
| mem_rd_data | input | ENT_W | Entry word, valid the cycle after the strobe |

## Verification
Two things can fall in the same cycle: delivering a finished lookup's response and accepting the next request, whose first table read starts at once. The bench provokes this by keeping a fresh request on the inputs throughout every lookup. That request is ignored while the block is busy and must be taken exactly in the response cycle. A behavioural model tracks busy state, read count and response timing cycle by cycle. Each cycle it judges the old response's fields, the acceptance, and the new request's hashed read address side by side.

// File: rtl/ipt_walker.sv
module ipt_walker #(
  parameter int VPN_W  = 20,
  parameter int PID_W  = 8,
  parameter int FLAG_W = 4,
  parameter int IDX_W  = 6,
  parameter int ADDR_W = 16,
  parameter int PROBES = 4,
  parameter int CNT_W  = $clog2(PROBES + 1),
  parameter int ENT_W  = 1 + FLAG_W + PID_W + VPN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [PID_W-1:0]  req_pid,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [IDX_W-1:0]  rsp_pfn,
  output logic [FLAG_W-1:0] rsp_flags,
  output logic [CNT_W-1:0]  rsp_probes,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [ENT_W-1:0]  mem_rd_data
);

  typedef enum logic {S_IDLE, S_CHECK} state_t;

  state_t            st;
  logic [VPN_W-1:0]  vpn_q;
  logic [PID_W-1:0]  pid_q;
  logic [IDX_W-1:0]  slot_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [IDX_W-1:0] fold(input logic [VPN_W-1:0] v,
                                           input logic [PID_W-1:0] p);
    logic [VPN_W-1:0] x;
    logic [IDX_W-1:0] h;
    x = v ^ VPN_W'(p);
    h = '0;
    for (int i = 0; i < VPN_W; i++) h[i % IDX_W] ^= x[i];
    return h;
  endfunction

  wire [VPN_W-1:0]  e_vpn   = mem_rd_data[VPN_W-1:0];
  wire [PID_W-1:0]  e_pid   = mem_rd_data[VPN_W +: PID_W];
  wire [FLAG_W-1:0] e_flags = mem_rd_data[VPN_W+PID_W +: FLAG_W];
  wire              e_valid = mem_rd_data[ENT_W-1];

  wire accept = req_valid && (st == S_IDLE);
  wire match  = e_valid && (e_vpn == vpn_q) && (e_pid == pid_q);
  wire last   = (cnt_q == CNT_W'(PROBES - 1));
  wire done   = (st == S_CHECK) && (match || !e_valid || last);

  wire [IDX_W-1:0] next_slot = slot_q + 1'b1;
  wire [IDX_W-1:0] rd_slot   = accept ? fold(req_vpn, req_pid) : next_slot;

  assign req_ready   = (st == S_IDLE);
  assign mem_rd_en   = accept || ((st == S_CHECK) && !done);
  assign mem_rd_addr = tbl_base + ADDR_W'(rd_slot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      vpn_q      <= '0;
      pid_q      <= '0;
      slot_q     <= '0;
      cnt_q      <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_pfn    <= '0;
      rsp_flags  <= '0;
      rsp_probes <= '0;
    end else begin
      rsp_valid <= done;
      if (accept) begin
        st     <= S_CHECK;
        vpn_q  <= req_vpn;
        pid_q  <= req_pid;
        slot_q <= rd_slot;
        cnt_q  <= '0;
      end else if (st == S_CHECK) begin
        if (done) begin
          st         <= S_IDLE;
          rsp_hit    <= match;
          rsp_fault  <= !match;
          rsp_pfn    <= slot_q;
          rsp_flags  <= match ? e_flags : '0;
          rsp_probes <= cnt_q + 1'b1;
        end else begin
          slot_q <= next_slot;
          cnt_q  <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

module ipt_walker_chk #(
  parameter int IDX_W  = 6,
  parameter int ADDR_W = 16,
  parameter int PROBES = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] tbl_base,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_fault,
  input logic [CNT_W-1:0]  rsp_probes,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr
);

  logic [IDX_W-1:0] off;
  assign off = IDX_W'(mem_rd_addr - tbl_base);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R9
  rsp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R4
  hit_xor_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_fault));

  // R7
  probe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_probes >= CNT_W'(1)) && (rsp_probes <= CNT_W'(PROBES)));

  // R10
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && req_ready |-> req_valid);

  // R3
  probe_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && !req_ready |-> $past(mem_rd_en) && (off == IDX_W'($past(off) + 1'b1)));

endmodule

bind ipt_walker ipt_walker_chk #(
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .PROBES(PROBES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
  .rsp_probes(rsp_probes), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr)
);

// File: tb/ipt_walker_bench.sv
`timescale 1ns/1ps
module ipt_walker_bench;
  localparam int VPN_W  = 20;
  localparam int PID_W  = 8;
  localparam int FLAG_W = 4;
  localparam int IDX_W  = 6;
  localparam int ADDR_W = 16;
  localparam int PROBES = 4;
  localparam int CNT_W  = $clog2(PROBES + 1);
  localparam int ENT_W  = 1 + FLAG_W + PID_W + VPN_W;
  localparam int E      = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] tbl_base = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [VPN_W-1:0]  req_vpn = '0;
  logic [PID_W-1:0]  req_pid = '0;
  logic              rsp_valid, rsp_hit, rsp_fault;
  logic [IDX_W-1:0]  rsp_pfn;
  logic [FLAG_W-1:0] rsp_flags;
  logic [CNT_W-1:0]  rsp_probes;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [ENT_W-1:0]  mem_rd_data = '0;

  logic [ENT_W-1:0]  tbl [E];

  int n_chk = 0;
  int n_err = 0;

  ipt_walker u_ipt_walker (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_pid(req_pid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_pfn(rsp_pfn), .rsp_flags(rsp_flags), .rsp_probes(rsp_probes),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk)
    if (mem_rd_en) mem_rd_data <= tbl[IDX_W'(mem_rd_addr - tbl_base)];

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int bhash(input int v, input int p);
    int x, h;
    x = v ^ p;
    h = 0;
    while (x != 0) begin
      h = h ^ (x % E);
      x = x / E;
    end
    return h;
  endfunction

  // reference model state
  int    m_busy = 0, m_k = 0, m_rsp = 0;
  int    e_h, e_n, e_hit, e_pfn, e_flags;
  string e_tag;
  int    r_n, r_hit, r_pfn, r_flags;
  string r_tag;

  task automatic predict(input int v, input int p);
    e_h = bhash(v, p);
    e_hit = 0; e_pfn = 0; e_flags = 0; e_n = PROBES; e_tag = "R7";
    for (int k = 0; k < PROBES; k++) begin
      int s;
      logic [ENT_W-1:0] en;
      s  = (e_h + k) % E;
      en = tbl[s];
      if (!en[ENT_W-1]) begin
        e_n = k + 1; e_tag = "R6";
        break;
      end
      if (int'(en[VPN_W-1:0]) == v && int'(en[VPN_W +: PID_W]) == p) begin
        e_hit = 1; e_pfn = s; e_flags = int'(en[VPN_W+PID_W +: FLAG_W]);
        e_n = k + 1; e_tag = "R5";
        break;
      end
    end
  endtask

  always @(negedge clk) begin
    int exp_en, nxt;
    if (!rst_n) begin
      m_busy = 0; m_k = 0; m_rsp = 0;
    end else begin
      chk("R9 ready", req_ready, !m_busy);
      exp_en = m_busy ? (m_k < e_n) : int'(req_valid);
      chk("R10 read strobe", mem_rd_en, exp_en);
      if (exp_en != 0 && mem_rd_en) begin
        if (m_busy)
          chk("R3 probe addr", mem_rd_addr, (int'(tbl_base) + (e_h + m_k) % E) & 16'hFFFF);
        else
          chk("R2 home addr", mem_rd_addr,
              (int'(tbl_base) + bhash(int'(req_vpn), int'(req_pid))) & 16'hFFFF);
      end
      chk("R8 rsp_valid", rsp_valid, m_rsp);
      if (m_rsp != 0 && rsp_valid) begin
        chk("R4 hit", rsp_hit, r_hit);
        chk("R4 fault", rsp_fault, !r_hit);
        chk("R4 flags", rsp_flags, r_flags);
        if (r_hit != 0) chk("R4 pfn", rsp_pfn, r_pfn);
        chk(r_tag, rsp_probes, r_n);
      end
      nxt = 0;
      if (m_busy != 0) begin
        if (m_k < e_n) m_k++;
        else begin
          m_busy = 0; nxt = 1;
          r_n = e_n; r_hit = e_hit; r_pfn = e_pfn; r_flags = e_flags; r_tag = e_tag;
        end
      end else if (req_valid) begin
        predict(int'(req_vpn), int'(req_pid));
        m_busy = 1; m_k = 1;
      end
      m_rsp = nxt;
    end
  end

  task automatic put(input int v, input int p);
    req_vpn = VPN_W'(v);
    req_pid = PID_W'(p);
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk);
    #1;
  endtask

  task automatic drain();
    req_valid = 1'b0;
    do @(posedge clk); while (m_busy != 0 || m_rsp != 0);
    #1;
  endtask

  task automatic clear_tbl();
    for (int i = 0; i < E; i++) tbl[i] = '0;
  endtask

  task automatic set_ent(input int s, input int v, input int p, input int f);
    tbl[s % E] = {1'b1, FLAG_W'(f), PID_W'(p), VPN_W'(v)};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int v, p, h;
    clear_tbl();
    tbl_base = 16'h0100;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 rd_en", mem_rd_en, 0);
    @(posedge clk); #1;

    v = 'h12345; p = 'h3c; h = bhash(v, p);
    // R4 hit in home slot
    set_ent(h, v, p, 5);
    put(v, p); drain();

    // R4 pid must match, R5 hit at third slot
    clear_tbl();
    set_ent(h, v + 1, p, 1);
    set_ent(h + 1, v, p + 1, 2);
    set_ent(h + 2, v, p, 9);
    put(v, p); drain();

    // R7 run exhausted, match past the run ignored
    clear_tbl();
    for (int k = 0; k < PROBES; k++) set_ent(h + k, v + 7, p, 3);
    set_ent(h + PROBES, v, p, 4);
    put(v, p); drain();

    // R6 empty slot ends search
    clear_tbl();
    set_ent(h, v + 2, p, 6);
    set_ent(h + 2, v, p, 6);
    put(v, p); drain();

    // R5 duplicate matches: first wins
    clear_tbl();
    set_ent(h, v, p, 10);
    set_ent(h + 1, v, p, 11);
    put(v, p); drain();

    // R3 wrap of the slot index, with address wrap of the base
    clear_tbl();
    tbl_base = 16'hFFF0;
    p = 7; v = 0;
    while (bhash(v, p) != E - 2) v++;
    set_ent(E - 2, v + 1, p, 1);
    set_ent(E - 1, v + 2, p, 1);
    set_ent(0, v + 3, p, 1);
    set_ent(1, v, p, 12);
    put(v, p); drain();

    // R9 back-to-back: next request held while busy, taken in rsp cycle
    put(v, p); put(v + 1, p); put(v, p); drain();

    // random table contents and request stream
    tbl_base = 16'h2A40;
    for (int i = 0; i < E; i++) begin
      if (($urandom % 4) != 0) set_ent(i, $urandom % 32, $urandom % 4, $urandom % 16);
      else tbl[i] = '0;
    end
    for (int n = 0; n < 300; n++) begin
      put($urandom % 32, $urandom % 4);
      if (($urandom % 5) == 0) drain();
    end
    drain();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule